// File: doc/BRIEF.md
# Flash Erase Pulse Sequencer

This controller steps the four control bits of an on-chip flash array through a block erase and then an erase verify. A start request begins the sequence. The controller raises the write-enable bit and then the erase-setup bit. It holds the erase bit for one pulse and lowers the bits again in the reverse order. It then enters verify mode, issues a one-cycle dummy write and samples a single pass/fail result from the array read path. Every step waits a minimum settle time in microseconds. The clock rate in MHz is a parameter, and the waits are counted from it.

When verification fails and fewer than `MAX_PULSES` pulses have been applied, the controller returns to the erase-setup step and applies another pulse. When verification passes, the controller lowers every bit and pulses `done`. When the last allowed pulse also fails verification, the controller lowers every bit and pulses `fail`. The total time the erase bit is high is therefore at most the pulse width times `MAX_PULSES`.

States and transitions:

- **IDLE → SWE_WAIT** on start.
- **SWE_WAIT → ESU_WAIT** when its timer expires.
- **ESU_WAIT → PULSE** when its timer expires.
- **PULSE → EOFF_WAIT** when its timer expires.
- **EOFF_WAIT → ESUOFF_WAIT** when its timer expires.
- **ESUOFF_WAIT → EV_WAIT** when its timer expires.
- **EV_WAIT → DUMMY** when its timer expires.
- **DUMMY → DUMMY_WAIT** always, after one cycle.
- **DUMMY_WAIT → SAMPLE** when its timer expires.
- **SAMPLE → EVOFF_WAIT** always, after one cycle.
- **EVOFF_WAIT** then branches on the sampled result:
  - **→ DONE_ST** when the verify passed.
  - **→ ESU_WAIT** (retry) when the verify failed and the pulse count is below the limit.
  - **→ FAIL_ST** when the verify failed at the limit.
- **DONE_ST → IDLE** and **FAIL_ST → IDLE** after one cycle.

Top module: `flash_erase_seq`

## Requirements
In these requirements, M is `CLK_MHZ` and D(t) = t·M+1 clock cycles. "Raise" and "lower" refer to output levels sampled once per cycle.
- R1: In idle, `start` raises `swe`. `esu` rises exactly D(`T_SWE_US`) cycles after `swe` rises.
- R2: `ers` rises exactly D(`T_ESU_US`) cycles after `esu` rises. `ers` is never high unless both `esu` and `swe` are high, and `esu` was already high in the previous cycle.
- R3: Each erase pulse keeps `ers` high for exactly D(`T_PULSE_US`) cycles.
- R4: `esu` falls D(`T_EOFF_US`) cycles after `ers` falls. `ev` rises D(`T_ESUOFF_US`) cycles after `esu` falls.
- R5: `dummy_wr` is a one-cycle pulse, raised only while `ev` is high, D(`T_EV_US`) cycles after `ev` rises. `verify_pass` is sampled in the cycle just before `ev` falls. `ev` falls D(`T_DUMMY_US`)+2 cycles after the dummy-write cycle. There is one dummy write per pulse.
- R6: D(`T_EVOFF_US`) cycles after `ev` falls, one of three things happens: `esu` rises again (retry), `done` rises, or `fail` rises.
- R7: A passing verify ends the run with `done` high for exactly one cycle. In that cycle `swe`, `esu`, `ers` and `ev` are all low, and no further pulse is applied.
- R8: Failing verifies repeat the pulse until `MAX_PULSES` pulses have been applied. When the verify after the last pulse fails, `fail` is high for one cycle with all control bits low. Never more than `MAX_PULSES` pulses occur per run.
- R9: `ers` and `ev` are never high in the same cycle.
- R10: `start` is ignored outside idle. A start raised during a run changes neither the pulse count nor the single `done`/`fail` of that run.
- R11: A synchronous `rst` lowers every output in the next cycle and returns the controller to idle, where it stays until a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an erase run (taken in idle only) |
| verify_pass | input | 1 | Verify result from the array read path, 1 = erased |
| swe | output | 1 | Software write-enable control bit |
| esu | output | 1 | Erase-setup control bit |
| ers | output | 1 | Erase control bit |
| ev | output | 1 | Erase-verify control bit |
| dummy_wr | output | 1 | One-cycle dummy-write strobe in verify mode |
| done | output | 1 | One-cycle pulse: erase verified |
| fail | output | 1 | One-cycle pulse: pulse limit reached without a pass |

## Verification
The assertions rely on one assumption about the inputs: `verify_pass` has any meaning only in the sampling cycle, so it is left unconstrained and only the control-bit ordering, the exclusivity and the pulse bound are checked. Reset is assumed to be held for at least one clock edge before the bits are trusted. The bench keeps within these assumptions by holding `verify_pass` as a plain level. That level goes high once a chosen number of dummy writes has been seen. The bench sweeps the passing pulse over every position up to the limit, plus a run that never passes. It raises `start` during a run and resets the block in the middle of a pulse.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [3:0] {
        IDLE,
        SWE_WAIT,
        ESU_WAIT,
        PULSE,
        EOFF_WAIT,
        ESUOFF_WAIT,
        EV_WAIT,
        DUMMY,
        DUMMY_WAIT,
        SAMPLE,
        EVOFF_WAIT,
        DONE_ST,
        FAIL_ST
    } seq_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/fes_us_timer.sv
module fes_us_timer #(
    parameter int CLK_MHZ = 16,
    parameter int US_W    = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [US_W-1:0] load_us,
    output logic            zero
);
    localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLK_MHZ - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;
    logic             tick;

    // prescaler restarts on every load so each wait is cycle-exact
    assign tick = (pre_q == PRE_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (load) begin
            pre_q <= '0;
            us_q  <= load_us;
        end else if (us_q != '0) begin
            if (tick) begin
                pre_q <= '0;
                us_q  <= us_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign zero = (us_q == '0);

endmodule

// File: rtl/fes_pulse_count.sv
module fes_pulse_count #(
    parameter int MAX_PULSES = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = flash_erase_pkg::width_for(MAX_PULSES);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q >= LIMIT);

endmodule

// File: rtl/fes_seq_fsm.sv
module fes_seq_fsm
    import flash_erase_pkg::*;
#(
    parameter int US_W         = 14,
    parameter int T_SWE_US     = 10,
    parameter int T_ESU_US     = 200,
    parameter int T_PULSE_US   = 10000,
    parameter int T_EOFF_US    = 10,
    parameter int T_ESUOFF_US  = 10,
    parameter int T_EV_US      = 20,
    parameter int T_DUMMY_US   = 2,
    parameter int T_EVOFF_US   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            verify_pass,
    input  logic            tmr_zero,
    input  logic            at_limit,
    output logic            tmr_load,
    output logic [US_W-1:0] tmr_us,
    output logic            cnt_clr,
    output logic            cnt_inc,
    output logic            swe,
    output logic            esu,
    output logic            ers,
    output logic            ev,
    output logic            dummy_wr,
    output logic            done,
    output logic            fail
);
    seq_state_t state_q, state_d;
    logic       passed_q;

    function automatic logic [US_W-1:0] wait_of(input seq_state_t s);
        logic [US_W-1:0] r;
        unique case (s)
            SWE_WAIT:    r = US_W'(T_SWE_US);
            ESU_WAIT:    r = US_W'(T_ESU_US);
            PULSE:       r = US_W'(T_PULSE_US);
            EOFF_WAIT:   r = US_W'(T_EOFF_US);
            ESUOFF_WAIT: r = US_W'(T_ESUOFF_US);
            EV_WAIT:     r = US_W'(T_EV_US);
            DUMMY_WAIT:  r = US_W'(T_DUMMY_US);
            EVOFF_WAIT:  r = US_W'(T_EVOFF_US);
            default:     r = '0;
        endcase
        return r;
    endfunction

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:        if (start)    state_d = SWE_WAIT;
            SWE_WAIT:    if (tmr_zero) state_d = ESU_WAIT;
            ESU_WAIT:    if (tmr_zero) state_d = PULSE;
            PULSE:       if (tmr_zero) state_d = EOFF_WAIT;
            EOFF_WAIT:   if (tmr_zero) state_d = ESUOFF_WAIT;
            ESUOFF_WAIT: if (tmr_zero) state_d = EV_WAIT;
            EV_WAIT:     if (tmr_zero) state_d = DUMMY;
            DUMMY:                     state_d = DUMMY_WAIT;
            DUMMY_WAIT:  if (tmr_zero) state_d = SAMPLE;
            SAMPLE:                    state_d = EVOFF_WAIT;
            EVOFF_WAIT: begin
                if (tmr_zero) begin
                    if (passed_q)      state_d = DONE_ST;
                    else if (at_limit) state_d = FAIL_ST;
                    else               state_d = ESU_WAIT;
                end
            end
            DONE_ST:                   state_d = IDLE;
            FAIL_ST:                   state_d = IDLE;
            default:                   state_d = IDLE;
        endcase
    end

    // state register and verify latch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= IDLE;
            passed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == IDLE && start)
                passed_q <= 1'b0;
            else if (state_q == SAMPLE)
                passed_q <= verify_pass;
        end
    end

    assign tmr_load = (state_d != state_q);
    assign tmr_us   = wait_of(state_d);
    assign cnt_clr  = (state_q == IDLE) && start;
    assign cnt_inc  = (state_q == ESU_WAIT) && (state_d == PULSE);

    // Moore outputs
    always_comb begin
        swe      = 1'b0;
        esu      = 1'b0;
        ers      = 1'b0;
        ev       = 1'b0;
        dummy_wr = 1'b0;
        done     = 1'b0;
        fail     = 1'b0;
        unique case (state_q)
            IDLE:        ;
            SWE_WAIT:    swe = 1'b1;
            ESU_WAIT:    begin swe = 1'b1; esu = 1'b1; end
            PULSE:       begin swe = 1'b1; esu = 1'b1; ers = 1'b1; end
            EOFF_WAIT:   begin swe = 1'b1; esu = 1'b1; end
            ESUOFF_WAIT: swe = 1'b1;
            EV_WAIT:     begin swe = 1'b1; ev = 1'b1; end
            DUMMY:       begin swe = 1'b1; ev = 1'b1; dummy_wr = 1'b1; end
            DUMMY_WAIT:  begin swe = 1'b1; ev = 1'b1; end
            SAMPLE:      begin swe = 1'b1; ev = 1'b1; end
            EVOFF_WAIT:  swe = 1'b1;
            DONE_ST:     done = 1'b1;
            FAIL_ST:     fail = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
    parameter int CLK_MHZ      = 16,
    parameter int T_SWE_US     = 10,
    parameter int T_ESU_US     = 200,
    parameter int T_PULSE_US   = 10000,
    parameter int T_EOFF_US    = 10,
    parameter int T_ESUOFF_US  = 10,
    parameter int T_EV_US      = 20,
    parameter int T_DUMMY_US   = 2,
    parameter int T_EVOFF_US   = 5,
    parameter int MAX_PULSES   = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic verify_pass,
    output logic swe,
    output logic esu,
    output logic ers,
    output logic ev,
    output logic dummy_wr,
    output logic done,
    output logic fail
);
    import flash_erase_pkg::*;

    localparam int MAX_US = max_of(max_of(max_of(T_SWE_US, T_ESU_US), max_of(T_PULSE_US, T_EOFF_US)),
                                   max_of(max_of(T_ESUOFF_US, T_EV_US), max_of(T_DUMMY_US, T_EVOFF_US)));
    localparam int US_W = width_for(MAX_US);

    logic            tmr_load;
    logic [US_W-1:0] tmr_us;
    logic            tmr_zero;
    logic            cnt_clr;
    logic            cnt_inc;
    logic            at_limit;

    fes_us_timer #(.CLK_MHZ(CLK_MHZ), .US_W(US_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_us (tmr_us),
        .zero    (tmr_zero)
    );

    fes_pulse_count #(.MAX_PULSES(MAX_PULSES)) u_count (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .at_limit (at_limit)
    );

    fes_seq_fsm #(
        .US_W        (US_W),
        .T_SWE_US    (T_SWE_US),
        .T_ESU_US    (T_ESU_US),
        .T_PULSE_US  (T_PULSE_US),
        .T_EOFF_US   (T_EOFF_US),
        .T_ESUOFF_US (T_ESUOFF_US),
        .T_EV_US     (T_EV_US),
        .T_DUMMY_US  (T_DUMMY_US),
        .T_EVOFF_US  (T_EVOFF_US)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .verify_pass (verify_pass),
        .tmr_zero    (tmr_zero),
        .at_limit    (at_limit),
        .tmr_load    (tmr_load),
        .tmr_us      (tmr_us),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .swe         (swe),
        .esu         (esu),
        .ers         (ers),
        .ev          (ev),
        .dummy_wr    (dummy_wr),
        .done        (done),
        .fail        (fail)
    );

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
    parameter int MAX_PULSES = 120
) (
    input logic clk,
    input logic rst,
    input logic swe,
    input logic esu,
    input logic ers,
    input logic ev,
    input logic dummy_wr,
    input logic done,
    input logic fail
);
    logic swe_p, ers_p;
    int   pulses;

    always_ff @(posedge clk) begin
        if (rst) begin
            swe_p  <= 1'b0;
            ers_p  <= 1'b0;
            pulses <= 0;
        end else begin
            swe_p <= swe;
            ers_p <= ers;
            if (swe && !swe_p)
                pulses <= 0;
            else if (ers && !ers_p)
                pulses <= pulses + 1;
        end
    end

    assert_ers_needs_setup_R2: assert property (@(posedge clk) disable iff (rst)
        ers |-> (esu && swe));
    assert_ers_after_esu_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ers) |-> $past(esu));
    assert_ers_ev_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(ers && ev));
    assert_dummy_in_verify_R5: assert property (@(posedge clk) disable iff (rst)
        dummy_wr |-> ev);
    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!swe && !esu && !ers && !ev && !fail));
    assert_fail_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        fail |-> (!swe && !esu && !ers && !ev));
    assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (rst)
        pulses <= MAX_PULSES);
    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (!swe && !esu && !ers && !ev && !dummy_wr && !done && !fail));

endmodule

bind flash_erase_seq flash_erase_seq_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .swe      (swe),
    .esu      (esu),
    .ers      (ers),
    .ev       (ev),
    .dummy_wr (dummy_wr),
    .done     (done),
    .fail     (fail)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ   = 2;
    localparam int TSWE  = 3;
    localparam int TESU  = 5;
    localparam int TPUL  = 7;
    localparam int TEOFF = 2;
    localparam int TSOFF = 2;
    localparam int TEV   = 3;
    localparam int TDUM  = 1;
    localparam int TVOFF = 2;
    localparam int MAXP  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic verify_pass;
    logic swe, esu, ers, ev, dummy_wr, done, fail;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int k_target = 0;

    int n_ers, n_dum, n_done, n_fail;
    int t_swe, t_esu1, t_ersr, t_ersf, t_esuf, t_evr, t_dum, t_evf1, t_evf, t_end;
    logic p_swe, p_esu, p_ers, p_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign verify_pass = (n_dum >= k_target);

    flash_erase_seq #(
        .CLK_MHZ(MHZ), .T_SWE_US(TSWE), .T_ESU_US(TESU), .T_PULSE_US(TPUL),
        .T_EOFF_US(TEOFF), .T_ESUOFF_US(TSOFF), .T_EV_US(TEV), .T_DUMMY_US(TDUM),
        .T_EVOFF_US(TVOFF), .MAX_PULSES(MAXP)
    ) i_flash_erase_seq (
        .clk(clk), .rst(rst), .start(start), .verify_pass(verify_pass),
        .swe(swe), .esu(esu), .ers(ers), .ev(ev), .dummy_wr(dummy_wr),
        .done(done), .fail(fail)
    );

    function automatic int dur(input int t);
        return t * MHZ + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_ers = 0; n_dum = 0; n_done = 0; n_fail = 0;
        t_swe = -1; t_esu1 = -1; t_ersr = -1; t_ersf = -1; t_esuf = -1;
        t_evr = -1; t_dum = -1; t_evf1 = -1; t_evf = -1; t_end = -1;
    endtask

    // event monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (swe && !p_swe) t_swe = cyc;
        if (esu && !p_esu) begin
            if (n_ers == 0) t_esu1 = cyc;
            else check("R6 retry gap", cyc - t_evf, dur(TVOFF));
        end
        if (ers && !p_ers) begin
            n_ers++;
            if (n_ers == 1) t_ersr = cyc;
        end
        if (!ers && p_ers && n_ers == 1) t_ersf = cyc;
        if (!esu && p_esu && n_ers == 1) t_esuf = cyc;
        if (ev && !p_ev && n_ers == 1) t_evr = cyc;
        if (dummy_wr) begin
            n_dum++;
            if (n_dum == 1) t_dum = cyc;
            check("R5 dummy in verify", int'(ev), 1);
        end
        if (!ev && p_ev) begin
            t_evf = cyc;
            if (t_evf1 < 0) t_evf1 = cyc;
        end
        if (done || fail) begin
            t_end = cyc;
            check("R7 bits low at end", int'({swe, esu, ers, ev}), 0);
            if (done) n_done++;
            if (fail) n_fail++;
        end
        if (ers && ev) check("R9 ers with ev", 1, 0);
        p_swe = swe; p_esu = esu; p_ers = ers; p_ev = ev;
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000 && (n_done + n_fail) == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run(input int k, input bit poke_start);
        int exp_p;
        exp_p = (k <= MAXP) ? k : MAXP;
        k_target = k;
        clear_log();
        pulse_start();
        if (poke_start) begin
            for (int i = 0; i < 2000 && !ers; i++) @(negedge clk);
            pulse_start();
        end
        wait_end();
        check("R1 swe to esu", t_esu1 - t_swe, dur(TSWE));
        check("R2 esu to ers", t_ersr - t_esu1, dur(TESU));
        check("R3 ers width", t_ersf - t_ersr, dur(TPUL));
        check("R4 ers fall to esu fall", t_esuf - t_ersf, dur(TEOFF));
        check("R4 esu fall to ev rise", t_evr - t_esuf, dur(TSOFF));
        check("R5 ev rise to dummy", t_dum - t_evr, dur(TEV));
        check("R5 dummy to ev fall", t_evf1 - t_dum, dur(TDUM) + 2);
        check("R5 dummy count", n_dum, exp_p);
        check("R6 ev fall to end", t_end - t_evf, dur(TVOFF));
        check("R8 pulse count", n_ers, exp_p);
        if (k <= MAXP) begin
            check("R7 done count", n_done, 1);
            check("R7 no fail", n_fail, 0);
        end else begin
            check("R8 fail count", n_fail, 1);
            check("R8 no done", n_done, 0);
        end
        if (poke_start) check("R10 start ignored pulses", n_ers, exp_p);
    endtask

    initial begin
        clear_log();
        p_swe = 0; p_esu = 0; p_ers = 0; p_ev = 0;
        repeat (3) @(negedge clk);
        check("R11 reset outputs", int'({swe, esu, ers, ev, dummy_wr, done, fail}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 idle without start", int'(swe), 0);

        for (int k = 1; k <= MAXP + 1; k++) run(k, 1'b0);
        run(2, 1'b1);
        run(MAXP + 1, 1'b1);

        // reset in the middle of a pulse
        k_target = 99;
        clear_log();
        pulse_start();
        for (int i = 0; i < 2000 && !ers; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 mid-pulse reset", int'({swe, esu, ers, ev, dummy_wr, done, fail}), 0);
        repeat (20) @(negedge clk);
        check("R11 stays idle", int'({swe, esu, ers, ev}), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule